// File: doc/BRIEF.md
# Digital Video Stream Formatter with Sync Extraction

This block sits on the output side of a digital video path. It accepts a 10-bit 4:2:2 multiplexed component stream, one word per pixel clock, where each line is framed by timing reference sequences. Each such sequence is four words: 3FFh, 000h, 000h, then a status word with the field (F), vertical blanking (V) and end/start (H) flags. The block sends the same stream out on a 10-bit bus. On the way it limits sample values to a selected legal range and leaves the reference sequences untouched. It also builds a horizontal and a vertical sync level in the digital path.

The horizontal level follows the H flag and changes at the third word of each reference sequence. The vertical level comes from a line counter. The counter locks to the field flag and switches on and off at fixed line numbers for each scan standard. A static input can place the two sync levels on the two lowest output bits in place of video. The line standard and the clip range are also static inputs. A disable input floats the output bus.

Top module: `bt656_fmt_top`

## Requirements
- R1: While reset is held and the output is enabled, vid_out is 000h.
- R2: Every input word reaches vid_out exactly 4 clock cycles after it is sampled. The four words of a reference sequence (3FFh, 000h, 000h, status word) are never clipped. The status word, including its V flag, is passed unchanged. In the status word, F is bit 8, V is bit 7 and H is bit 6; H=1 marks end of active video and H=0 marks start.
- R3: With clip_narrow=1, every sample outside a reference sequence is clamped to at least 64, luma to at most 940 and chroma to at most 960.
- R4: With clip_narrow=0, every sample outside a reference sequence is clamped to the range 5..1019, whether it is luma or chroma.
- R5: Samples run in the order Cb, Y, Cr, Y. The order restarts at the first word after each status word, so the 2nd and 4th samples of each group are luma. In narrow mode, a value from 941 to 960 passes on a chroma position and becomes 940 on a luma position.
- R6: The horizontal sync level becomes 1 on the output cycle of the third word of an end-of-active sequence. It becomes 0 on the output cycle of the third word of a start-of-active sequence.
- R7: With sync_on_lsb=1, vid_out[1] carries the horizontal level and vid_out[0] the vertical level, and bits 9..2 carry the formatted word. With sync_on_lsb=0, all ten bits carry the formatted word.
- R8: The line number advances at each end-of-active sequence and wraps after the last line of the frame (625 or 525) to line 1. When F differs from its value at the previous end-of-active sequence, the line is loaded instead. With F=0 the load is line 1 in 625-line mode and line 4 in 525-line mode. With F=1 it is line 313 or line 266. Until the first such F change, the vertical level stays 0.
- R9: In 625-line mode (std_625=1), the vertical level is set to 1 on reaching line 623 or 309 and cleared on reaching line 21 or 335. It changes on the same output word as the horizontal level at that end-of-active sequence.
- R10: In 525-line mode (std_625=0), the vertical level is set on reaching line 2 or 265 and cleared on reaching line 21 or 284. It uses the same timing as R9.
- R11: While data_dis=1, vid_out is released (high impedance) in the same cycle, whatever the rest of the block is doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_in | input | 10 | Incoming multiplexed video word |
| std_625 | input | 1 | 1 selects 625-line numbering, 0 selects 525-line |
| clip_narrow | input | 1 | 1 selects the narrow luma/chroma ranges, 0 the wide range |
| sync_on_lsb | input | 1 | 1 puts horizontal/vertical sync on bits 1/0 |
| data_dis | input | 1 | 1 floats the output bus |
| vid_out | output | 10 | Formatted video word, or high impedance |

## Verification
The hardest state to reach from the ports is the vertical level around the line counter's first lock. A line that would set the level occurs before the first field change and must leave it low. After the lock, the 525-line wrap from line 525 through lines 1 to 3 must reach the set line 2 before the load to line 4. The stimulus builds full lines with correct status words and starts each run in the middle of a field, a few lines before a set line. It then runs on through one field change, a frame wrap and the next field. Samples are drawn from a list of boundary values whose length is odd, so each value falls on both luma and chroma positions.

// File: rtl/bt656_fmt_pkg.sv
package bt656_fmt_pkg;

    // word and counter widths
    localparam int VID_W   = 10;
    localparam int LINE_W  = 10;
    // reference sequence length in words (preamble of three plus status)
    localparam int TRS_LEN = 4;

    // per-standard line numbers
    localparam int L625_TOTAL  = 625;
    localparam int L625_F0_TOP = 1;
    localparam int L625_F1_TOP = 313;
    localparam int L625_ON_A   = 623;
    localparam int L625_ON_B   = 309;
    localparam int L625_OFF_A  = 21;
    localparam int L625_OFF_B  = 335;

    localparam int L525_TOTAL  = 525;
    localparam int L525_F0_TOP = 4;
    localparam int L525_F1_TOP = 266;
    localparam int L525_ON_A   = 2;
    localparam int L525_ON_B   = 265;
    localparam int L525_OFF_A  = 21;
    localparam int L525_OFF_B  = 284;

    // flags taken from a status word
    typedef struct packed {
        logic f;
        logic h;
    } trs_flags_t;

endpackage

// File: rtl/bt656_trs_align.sv
module bt656_trs_align
    import bt656_fmt_pkg::*;
#(
    parameter int DW = VID_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] vid_in,
    output logic [DW-1:0] word_o,
    output logic          trs_o,
    output logic [1:0]    pos_o,
    output logic          luma_o,
    output logic          hdr_o,
    output trs_flags_t    flags_o
);

    localparam int            DEPTH = TRS_LEN;
    localparam logic [DW-1:0] ONES  = '1;
    localparam logic [DW-1:0] ZERO  = '0;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] pipe;   // [0] newest, [DEPTH-1] word being formatted
        logic [1:0]               left;   // sequence words still to come
        logic [1:0]               phase;  // Cb, Y, Cr, Y
    } align_st_t;

    align_st_t align_q, align_d;
    logic      match;

    always_comb begin
        align_d = align_q;

        align_d.pipe[0] = vid_in;
        for (int i = 1; i < DEPTH; i++) begin
            align_d.pipe[i] = align_q.pipe[i-1];
        end

        // preamble at the oldest three stages, status word at the newest
        match = (align_q.left == 2'd0)
             && (align_q.pipe[DEPTH-1] == ONES)
             && (align_q.pipe[DEPTH-2] == ZERO)
             && (align_q.pipe[DEPTH-3] == ZERO);

        trs_o  = match || (align_q.left != 2'd0);
        // words left 3,2,1 map to positions 1,2,3 (modulo four)
        pos_o  = match ? 2'd0 : (2'd0 - align_q.left);
        hdr_o  = match;
        word_o = align_q.pipe[DEPTH-1];
        luma_o = align_q.phase[0];

        flags_o.f = align_q.pipe[0][DW-2];
        flags_o.h = align_q.pipe[0][DW-4];

        if (match) begin
            align_d.left = 2'(DEPTH - 1);
        end else if (align_q.left != 2'd0) begin
            align_d.left = align_q.left - 2'd1;
        end

        if (trs_o && (pos_o == 2'd3)) begin
            align_d.phase = 2'd0;
        end else if (!trs_o) begin
            align_d.phase = align_q.phase + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            align_q <= '0;
        end else begin
            align_q <= align_d;
        end
    end

    // R2: a detected preamble is followed by the rest of its sequence
    a_r2_trs_run: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_o |=> (trs_o && (pos_o == 2'd1)));

    // R5: the first word after a status word is a chroma position
    a_r5_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (trs_o && (pos_o == 2'd3)) |=> !luma_o);

endmodule

// File: rtl/bt656_clip.sv
module bt656_clip #(
    parameter int DW       = 10,
    parameter int NAR_LO   = 64,
    parameter int NAR_Y_HI = 940,
    parameter int NAR_C_HI = 960,
    parameter int WIDE_LO  = 5,
    parameter int WIDE_HI  = 1019
) (
    input  logic [DW-1:0] smp_i,
    input  logic          narrow_i,
    input  logic          luma_i,
    output logic [DW-1:0] smp_o
);

    localparam logic [DW-1:0] N_LO   = DW'(NAR_LO);
    localparam logic [DW-1:0] N_Y_HI = DW'(NAR_Y_HI);
    localparam logic [DW-1:0] N_C_HI = DW'(NAR_C_HI);
    localparam logic [DW-1:0] W_LO   = DW'(WIDE_LO);
    localparam logic [DW-1:0] W_HI   = DW'(WIDE_HI);

    logic [DW-1:0] lo_lim;
    logic [DW-1:0] hi_lim;

    always_comb begin
        lo_lim = narrow_i ? N_LO : W_LO;
        if (narrow_i) begin
            hi_lim = luma_i ? N_Y_HI : N_C_HI;
        end else begin
            hi_lim = W_HI;
        end

        if (smp_i < lo_lim) begin
            smp_o = lo_lim;
        end else if (smp_i > hi_lim) begin
            smp_o = hi_lim;
        end else begin
            smp_o = smp_i;
        end
    end

endmodule

// File: rtl/bt656_sync_gen.sv
module bt656_sync_gen
    import bt656_fmt_pkg::*;
#(
    parameter int LW = LINE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       std_625,
    input  logic       trs_i,
    input  logic [1:0] pos_i,
    input  logic       hdr_i,
    input  trs_flags_t flags_i,
    output logic       hs_o,
    output logic       vs_o
);

    typedef struct packed {
        trs_flags_t    pend;
        logic          hs;
        logic          vs;
        logic [LW-1:0] line;
        logic          f_prev;
        logic          f_seen;
        logic          synced;
    } sync_st_t;

    sync_st_t sync_q, sync_d;

    logic [LW-1:0] total, f0_top, f1_top, on_a, on_b, off_a, off_b;
    logic [LW-1:0] nline;
    logic          upd;

    always_comb begin
        total  = std_625 ? LW'(L625_TOTAL)  : LW'(L525_TOTAL);
        f0_top = std_625 ? LW'(L625_F0_TOP) : LW'(L525_F0_TOP);
        f1_top = std_625 ? LW'(L625_F1_TOP) : LW'(L525_F1_TOP);
        on_a   = std_625 ? LW'(L625_ON_A)   : LW'(L525_ON_A);
        on_b   = std_625 ? LW'(L625_ON_B)   : LW'(L525_ON_B);
        off_a  = std_625 ? LW'(L625_OFF_A)  : LW'(L525_OFF_A);
        off_b  = std_625 ? LW'(L625_OFF_B)  : LW'(L525_OFF_B);
    end

    // second word of a sequence is in the format stage: the levels then
    // take effect on the third word
    assign upd = trs_i && (pos_i == 2'd1);

    always_comb begin
        sync_d = sync_q;
        nline  = sync_q.line;

        if (hdr_i) begin
            sync_d.pend = flags_i;
        end

        if (upd) begin
            sync_d.hs = sync_q.pend.h;
            if (sync_q.pend.h) begin
                if (!sync_q.f_seen) begin
                    sync_d.f_seen = 1'b1;
                    sync_d.f_prev = sync_q.pend.f;
                end else if (sync_q.pend.f != sync_q.f_prev) begin
                    sync_d.f_prev = sync_q.pend.f;
                    sync_d.synced = 1'b1;
                    sync_d.line   = sync_q.pend.f ? f1_top : f0_top;
                end else if (sync_q.synced) begin
                    sync_d.line = (sync_q.line == total) ? LW'(1) : sync_q.line + LW'(1);
                end

                nline = sync_d.line;
                if (sync_d.synced) begin
                    if ((nline == on_a) || (nline == on_b)) begin
                        sync_d.vs = 1'b1;
                    end else if ((nline == off_a) || (nline == off_b)) begin
                        sync_d.vs = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign hs_o = sync_q.hs;
    assign vs_o = sync_q.vs;

    // R6: the horizontal level moves only after a sequence's second word
    a_r6_hs_edge_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q.hs != $past(sync_q.hs)) |-> $past(trs_i && (pos_i == 2'd1)));

    // R8: no vertical level before the counter has locked
    a_r8_vs_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_q.synced |-> !sync_q.vs);

    // R8: a locked counter stays inside the frame
    a_r8_line_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q.synced |-> ((sync_q.line != '0) && (sync_q.line <= total)));

    // R9: the vertical level moves only when an end-of-active sequence is taken
    a_r9_vs_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q.vs != $past(sync_q.vs)) |-> $past(upd && sync_q.pend.h));

endmodule

// File: rtl/bt656_fmt_top.sv
module bt656_fmt_top
    import bt656_fmt_pkg::*;
#(
    parameter int DW       = VID_W,
    parameter int LW       = LINE_W,
    parameter int NAR_LO   = 64,
    parameter int NAR_Y_HI = 940,
    parameter int NAR_C_HI = 960,
    parameter int WIDE_LO  = 5,
    parameter int WIDE_HI  = 1019
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] vid_in,
    input  logic          std_625,
    input  logic          clip_narrow,
    input  logic          sync_on_lsb,
    input  logic          data_dis,
    output logic [DW-1:0] vid_out
);

    typedef struct packed {
        logic [DW-1:0] word;
    } out_st_t;

    out_st_t       out_q, out_d;

    logic [DW-1:0] cur_word;
    logic          cur_trs;
    logic [1:0]    cur_pos;
    logic          cur_luma;
    logic          cur_hdr;
    trs_flags_t    cur_flags;
    logic [DW-1:0] clipped;
    logic          hs_lvl;
    logic          vs_lvl;
    logic [DW-1:0] chosen;

    bt656_trs_align #(.DW(DW)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .vid_in  (vid_in),
        .word_o  (cur_word),
        .trs_o   (cur_trs),
        .pos_o   (cur_pos),
        .luma_o  (cur_luma),
        .hdr_o   (cur_hdr),
        .flags_o (cur_flags)
    );

    bt656_clip #(
        .DW       (DW),
        .NAR_LO   (NAR_LO),
        .NAR_Y_HI (NAR_Y_HI),
        .NAR_C_HI (NAR_C_HI),
        .WIDE_LO  (WIDE_LO),
        .WIDE_HI  (WIDE_HI)
    ) u_clip (
        .smp_i    (cur_word),
        .narrow_i (clip_narrow),
        .luma_i   (cur_luma),
        .smp_o    (clipped)
    );

    bt656_sync_gen #(.LW(LW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .std_625 (std_625),
        .trs_i   (cur_trs),
        .pos_i   (cur_pos),
        .hdr_i   (cur_hdr),
        .flags_i (cur_flags),
        .hs_o    (hs_lvl),
        .vs_o    (vs_lvl)
    );

    always_comb begin
        chosen = cur_trs ? cur_word : clipped;
        if (sync_on_lsb) begin
            out_d.word = {chosen[DW-1:2], hs_lvl, vs_lvl};
        end else begin
            out_d.word = chosen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign vid_out = data_dis ? {DW{1'bz}} : out_q.word;

    // R2: sequence words leave the block as they came in
    a_r2_trs_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_trs && !sync_on_lsb) |=> (out_q.word == $past(cur_word)));

    // R3: narrow range bounds on every sample
    a_r3_narrow_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_trs && clip_narrow) |->
            ((clipped >= DW'(NAR_LO)) && (clipped <= DW'(NAR_C_HI))));

    // R4: wide range bounds on every sample
    a_r4_wide_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_trs && !clip_narrow) |->
            ((clipped >= DW'(WIDE_LO)) && (clipped <= DW'(WIDE_HI))));

    // R5: luma positions use the lower narrow ceiling
    a_r5_luma_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_trs && clip_narrow && cur_luma) |-> (clipped <= DW'(NAR_Y_HI)));

    // R7: sync levels on the two low bits
    a_r7_lsb_sync: assert property (@(posedge clk) disable iff (!rst_n)
        sync_on_lsb |=> (out_q.word[1:0] == $past({hs_lvl, vs_lvl})));

endmodule

// File: tb/bt656_fmt_top_bench.sv
module bt656_fmt_top_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic [9:0] vid_in;
    logic       std_625;
    logic       clip_narrow;
    logic       sync_on_lsb;
    logic       data_dis;
    wire  [9:0] vid_out;

    bt656_fmt_top u_bt656_fmt_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .vid_in      (vid_in),
        .std_625     (std_625),
        .clip_narrow (clip_narrow),
        .sync_on_lsb (sync_on_lsb),
        .data_dis    (data_dis),
        .vid_out     (vid_out)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    logic [9:0] q_exp[$];
    string      q_tag[$];
    string      q_vtag[$];

    bit m_hs;
    bit m_vs;
    bit m_synced;
    int m_fprev;
    int smp_cnt;

    int smp_tab [19] = '{1, 4, 5, 6, 63, 64, 65, 500, 939, 940, 941, 950,
                         959, 960, 961, 1018, 1019, 1020, 1023};

    task automatic check(input bit ok, input string tag,
                         input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] fmt(input logic [9:0] w);
        return sync_on_lsb ? {w[9:2], m_hs, m_vs} : w;
    endfunction

    // one word per cycle; the output is compared 4 sampling edges later
    task automatic send_word(input logic [9:0] w, input logic [9:0] e, input string tag);
        logic [9:0] ee;
        string      tt;
        string      vt;
        @(negedge clk);
        if (q_exp.size() == 5) begin
            ee = q_exp.pop_front();
            tt = q_tag.pop_front();
            vt = q_vtag.pop_front();
            if (data_dis)
                check((vid_out === 10'bz) || (vid_out === 10'b0), "R11", vid_out, 10'bz);
            else if (vid_out[9:2] !== ee[9:2])
                check(1'b0, tt, vid_out, ee);
            else if (vid_out[1] !== ee[1])
                check(1'b0, sync_on_lsb ? "R6/R7" : tt, vid_out, ee);
            else if (vid_out[0] !== ee[0])
                check(1'b0, sync_on_lsb ? vt : tt, vid_out, ee);
            else
                check(1'b1, tt, vid_out, ee);
        end
        vid_in = w;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        q_vtag.push_back(m_synced ? (std_625 ? "R9" : "R10") : "R8");
    endtask

    // vertical level model: lock at first F change, then fixed line numbers
    task automatic vs_model(input bit f, input int line);
        if (m_fprev < 0) begin
            m_fprev = int'(f);
        end else if (int'(f) != m_fprev) begin
            m_fprev  = int'(f);
            m_synced = 1'b1;
        end
        if (m_synced) begin
            if (std_625) begin
                if (line == 623 || line == 309) m_vs = 1'b1;
                if (line == 21  || line == 335) m_vs = 1'b0;
            end else begin
                if (line == 2   || line == 265) m_vs = 1'b1;
                if (line == 21  || line == 284) m_vs = 1'b0;
            end
        end
    endtask

    task automatic send_trs(input bit f, input bit v, input bit h, input int line);
        logic [9:0] words [4];
        words[0] = 10'h3FF;
        words[1] = 10'h000;
        words[2] = 10'h000;
        words[3] = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
        for (int k = 0; k < 4; k++) begin
            if (k == 2) begin
                m_hs = h;
                if (h) vs_model(f, line);
            end
            send_word(words[k], fmt(words[k]), "R2");
        end
    endtask

    task automatic send_samples(input int n);
        for (int k = 0; k < n; k++) begin
            int    v;
            int    lo;
            int    hi;
            int    c;
            bit    luma;
            string tag;
            v    = smp_tab[smp_cnt % 19];
            smp_cnt++;
            luma = (k % 2) == 1;
            if (clip_narrow) begin
                lo  = 64;
                hi  = luma ? 940 : 960;
                tag = (v >= 941 && v <= 960) ? "R5" : "R3";
            end else begin
                lo  = 5;
                hi  = 1019;
                tag = "R4";
            end
            c = (v < lo) ? lo : ((v > hi) ? hi : v);
            send_word(10'(v), fmt(10'(c)), tag);
        end
    endtask

    task automatic send_line(input int line);
        bit f;
        bit v;
        if (std_625) begin
            f = (line >= 313);
            v = (line <= 22) || (line >= 311 && line <= 335) || (line >= 624);
        end else begin
            f = (line >= 266) || (line <= 3);
            v = (line <= 19) || (line >= 264 && line <= 282);
        end
        send_trs(f, v, 1'b1, line);
        send_samples(4);
        send_trs(f, v, 1'b0, line);
        send_samples(8);
    endtask

    task automatic run_lines(input int start, input int count);
        int line;
        int total;
        line  = start;
        total = std_625 ? 625 : 525;
        for (int n = 0; n < count; n++) begin
            send_line(line);
            line = (line == total) ? 1 : line + 1;
        end
    endtask

    task automatic do_reset(input bit s625, input bit narrow, input bit sync);
        @(negedge clk);
        rst_n       = 1'b0;
        std_625     = s625;
        clip_narrow = narrow;
        sync_on_lsb = sync;
        data_dis    = 1'b0;
        vid_in      = 10'h000;
        q_exp.delete();
        q_tag.delete();
        q_vtag.delete();
        m_hs     = 1'b0;
        m_vs     = 1'b0;
        m_synced = 1'b0;
        m_fprev  = -1;
        repeat (2) @(negedge clk);
        check(vid_out === 10'h000, "R1", vid_out, 10'h000);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n       = 1'b0;
        vid_in      = 10'h000;
        std_625     = 1'b1;
        clip_narrow = 1'b0;
        sync_on_lsb = 1'b0;
        data_dis    = 1'b0;
        smp_cnt     = 0;

        // 625 lines, wide range, sync on the low bits: lock, wrap, all four edges
        do_reset(1'b1, 1'b0, 1'b1);
        run_lines(300, 666);

        // 625 lines, narrow range, plain video
        do_reset(1'b1, 1'b1, 1'b0);
        run_lines(100, 20);

        // 525 lines, narrow range, sync on the low bits
        do_reset(1'b0, 1'b1, 1'b1);
        run_lines(250, 566);

        // 525 lines, wide range, then the output disable in mid-stream
        do_reset(1'b0, 1'b0, 1'b0);
        run_lines(50, 10);
        data_dis = 1'b1;
        run_lines(60, 2);
        data_dis = 1'b0;
        run_lines(62, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule